// File: doc/BRIEF.md
# Structured 2:4 Sparse Dot-Product Unit

This block computes the dot product of a pruned weight vector and a dense activation vector. The weights obey a fixed sparsity pattern: within every aligned group of four, no more than two are nonzero. Storage keeps only those two values and a pair of small position indices. The activations arrive dense, four per group. For each group the unit uses the indices to select two of the four activations. It multiplies them by the two kept weights and adds both products into a wide signed running sum. The unit therefore does two multiplies per group where a dense unit would do four.

One group arrives per input beat over a valid/ready handshake. A last flag on a beat closes the vector, so a vector may hold any number of groups. The cycle after the closing beat is accepted, a result pulse presents the full sum. The next beat then starts a fresh sum. A group whose indices are not strictly increasing is malformed. It adds nothing, and it sets an error flag that stays set until reset.

Top module: `sp24_dot`

## Requirements
- R1: A group contributes `w0*a[i0] + w1*a[i1]`, all values signed 8-bit. Here w0 is `grp_wgt[7:0]`, w1 is `grp_wgt[15:8]`, i0 is `grp_idx[1:0]`, i1 is `grp_idx[3:2]`, and activation lane k is `grp_act[8k+7:8k]`.
- R2: The two activation lanes not named by the group's indices have no effect on the result.
- R3: Contributions accumulate in a 32-bit signed sum across all groups of a vector. A 1024-group vector of extreme values (-128 times -128 in both slots) gives the exact sum 33554432.
- R4: `grp_ready` is low during reset and high from the first cycle after reset. Each cycle with `grp_valid` and `grp_ready` both high consumes exactly one group.
- R5: `res_valid` is high for exactly one cycle, the cycle after a beat with `grp_last` set is accepted. In that cycle `res_sum` holds the sum of the vector. `res_valid` stays low at all other times.
- R6: A group with i0 >= i1 contributes zero and sets `meta_err`. `meta_err` then stays high until reset.
- R7: After a result, the next vector's sum starts from zero. `res_sum` keeps its value until the next result.
- R8: While reset is asserted, `res_valid`, `res_sum` and `meta_err` are zero.
- R9: Cycles with `grp_valid` low change neither the running sum nor any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 1 | Group beat offered |
| grp_ready | output | 1 | Unit accepts a group this cycle |
| grp_wgt | input | 16 | Two kept signed weights, slot 0 in the low byte |
| grp_idx | input | 4 | Two 2-bit lane indices, slot 0 in the low bits |
| grp_act | input | 32 | Four signed activations, lane 0 in the low byte |
| grp_last | input | 1 | Beat closes the vector |
| res_valid | output | 1 | One-cycle result strobe |
| res_sum | output | 32 | Signed dot product of the last vector |
| meta_err | output | 1 | Sticky malformed-metadata flag |

## Verification
The hardest case to reach is a malformed group in the middle of a vector. It must add nothing, but the groups around it must still count, and the flag must survive the results and the later clean vectors. The stimulus places equal and reversed index pairs between well-formed groups. After that it runs several clean vectors and compares every result with the reference model. A separate long run of 1024 extreme groups drives the sum toward its largest value.

// File: rtl/sp24_pkg.sv
package sp24_pkg;
    parameter int unsigned VAL_W  = 8;
    parameter int unsigned ACC_W  = 32;
    parameter int unsigned LANES  = 4;
    parameter int unsigned KEEP   = 2;
    localparam int unsigned IDX_W  = $clog2(LANES);
    localparam int unsigned PROD_W = 2 * VAL_W;

    typedef logic signed [VAL_W-1:0]  val_t;
    typedef logic [IDX_W-1:0]         idx_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        logic [KEEP-1:0][VAL_W-1:0]  wgt;
        logic [KEEP-1:0][IDX_W-1:0]  idx;
        logic [LANES-1:0][VAL_W-1:0] act;
        logic                        last;
    } beat_t;

    // Indices must rise strictly from slot to slot.
    function automatic logic meta_legal(input logic [KEEP-1:0][IDX_W-1:0] ix);
        logic ok;
        ok = 1'b1;
        for (int s = 1; s < KEEP; s++) begin
            if (ix[s] <= ix[s-1]) ok = 1'b0;
        end
        return ok;
    endfunction
endpackage

// File: rtl/sp24_select.sv
module sp24_select
    import sp24_pkg::*;
(
    input  logic [LANES-1:0][VAL_W-1:0] act,
    input  logic [KEEP-1:0][IDX_W-1:0]  idx,
    output logic [KEEP-1:0][VAL_W-1:0]  pick
);
    for (genvar s = 0; s < KEEP; s++) begin : g_slot
        always_comb begin
            pick[s] = '0;
            for (int l = 0; l < LANES; l++) begin
                if (idx[s] == IDX_W'(l)) pick[s] = act[l];
            end
        end
    end
endmodule

// File: rtl/sp24_macpair.sv
module sp24_macpair
    import sp24_pkg::*;
(
    input  logic [KEEP-1:0][VAL_W-1:0] wgt,
    input  logic [KEEP-1:0][VAL_W-1:0] pick,
    input  logic                       legal,
    output acc_t                       term
);
    prod_t prod [KEEP];

    for (genvar s = 0; s < KEEP; s++) begin : g_mul
        assign prod[s] = $signed(wgt[s]) * $signed(pick[s]);
    end

    always_comb begin
        term = '0;
        if (legal) begin
            for (int s = 0; s < KEEP; s++) begin
                term = term + acc_t'(prod[s]);
            end
        end
    end
endmodule

// File: rtl/sp24_accum.sv
module sp24_accum
    import sp24_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic close,
    input  acc_t term,
    output logic res_valid,
    output acc_t res_sum
);
    acc_t run_q;
    acc_t run_next;

    assign run_next = run_q + term;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= '0;
            res_valid <= 1'b0;
            res_sum   <= '0;
        end else begin
            res_valid <= take && close;
            if (take) begin
                if (close) begin
                    res_sum <= run_next;
                    run_q   <= '0;
                end else begin
                    run_q   <= run_next;
                end
            end
        end
    end
endmodule

// File: rtl/sp24_dot.sv
module sp24_dot
    import sp24_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     grp_valid,
    output logic                     grp_ready,
    input  logic [KEEP*VAL_W-1:0]    grp_wgt,
    input  logic [KEEP*IDX_W-1:0]    grp_idx,
    input  logic [LANES*VAL_W-1:0]   grp_act,
    input  logic                     grp_last,
    output logic                     res_valid,
    output logic [ACC_W-1:0]         res_sum,
    output logic                     meta_err
);
    beat_t                      beat;
    logic [KEEP-1:0][VAL_W-1:0] pick;
    logic                       legal;
    logic                       take;
    acc_t                       term;
    acc_t                       sum_q;

    assign beat.wgt  = grp_wgt;
    assign beat.idx  = grp_idx;
    assign beat.act  = grp_act;
    assign beat.last = grp_last;

    assign legal = meta_legal(beat.idx);
    assign take  = grp_valid && grp_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_ready <= 1'b0;
            meta_err  <= 1'b0;
        end else begin
            grp_ready <= 1'b1;
            if (take && !legal) meta_err <= 1'b1;
        end
    end

    sp24_select u_sel (
        .act  (beat.act),
        .idx  (beat.idx),
        .pick (pick)
    );

    sp24_macpair u_mac (
        .wgt   (beat.wgt),
        .pick  (pick),
        .legal (legal),
        .term  (term)
    );

    sp24_accum u_acc (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .close     (beat.last),
        .term      (term),
        .res_valid (res_valid),
        .res_sum   (sum_q)
    );

    assign res_sum = sum_q;
endmodule

// File: rtl/sp24_dot_chk.sv
module sp24_dot_chk
    import sp24_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   grp_valid,
    input logic                   grp_ready,
    input logic [KEEP*IDX_W-1:0]  grp_idx,
    input logic                   grp_last,
    input logic                   res_valid,
    input logic [ACC_W-1:0]       res_sum,
    input logic                   meta_err
);
    p_ready_up_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> grp_ready);

    p_pulse_cause_r5: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(grp_valid && grp_ready && grp_last));

    p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
        !(grp_valid && grp_ready && grp_last) |=> !res_valid);

    p_err_set_r6: assert property (@(posedge clk) disable iff (rst)
        (grp_valid && grp_ready && (grp_idx[3:2] <= grp_idx[1:0])) |=> meta_err);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        meta_err |=> meta_err);

    p_hold_sum_r7: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> $stable(res_sum));
endmodule

bind sp24_dot sp24_dot_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .grp_valid (grp_valid),
    .grp_ready (grp_ready),
    .grp_idx   (grp_idx),
    .grp_last  (grp_last),
    .res_valid (res_valid),
    .res_sum   (res_sum),
    .meta_err  (meta_err)
);

// File: tb/sim_sp24_dot.sv
module sim_sp24_dot;
    logic        clk = 1'b0;
    logic        rst;
    logic        grp_valid;
    logic        grp_ready;
    logic [15:0] grp_wgt;
    logic [3:0]  grp_idx;
    logic [31:0] grp_act;
    logic        grp_last;
    logic        res_valid;
    logic [31:0] res_sum;
    logic        meta_err;

    int checks   = 0;
    int failures = 0;
    string tag   = "R8";

    longint m_acc = 0;
    longint m_res = 0;
    bit     m_rv  = 0;
    bit     m_err = 0;

    always #5 clk = ~clk;

    sp24_dot u0 (
        .clk(clk), .rst(rst), .grp_valid(grp_valid), .grp_ready(grp_ready),
        .grp_wgt(grp_wgt), .grp_idx(grp_idx), .grp_act(grp_act),
        .grp_last(grp_last), .res_valid(res_valid), .res_sum(res_sum),
        .meta_err(meta_err)
    );

    task automatic check(input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("grp_ready", longint'(grp_ready), 1);
        check("res_valid", longint'(res_valid), longint'(m_rv));
        check("res_sum", longint'($signed(res_sum)), m_res);
        check("meta_err", longint'(meta_err), longint'(m_err));
    endtask

    function automatic longint lane(input logic [31:0] a, input int k);
        return longint'($signed(a[8*k +: 8]));
    endfunction

    // One clock: drive at negedge, model at posedge, compare at next negedge.
    task automatic beat(input bit v, input logic [7:0] w0, input logic [7:0] w1,
                        input logic [1:0] i0, input logic [1:0] i1,
                        input logic [31:0] a, input bit last);
        longint c;
        bit rdy;
        grp_valid = v;
        grp_wgt   = {w1, w0};
        grp_idx   = {i1, i0};
        grp_act   = a;
        grp_last  = last;
        rdy = grp_ready;
        @(posedge clk);
        m_rv = 0;
        if (v && rdy) begin
            if (i0 < i1) c = longint'($signed(w0)) * lane(a, i0) + longint'($signed(w1)) * lane(a, i1);
            else begin c = 0; m_err = 1; end
            if (last) begin m_res = m_acc + c; m_rv = 1; m_acc = 0; end
            else m_acc = m_acc + c;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        beat(0, 8'h7f, 8'h7f, 2'd0, 2'd1, 32'h7f7f7f7f, 1'b1);
    endtask

    task automatic rand_beat(input bit last);
        logic [1:0] a, b;
        a = 2'($urandom_range(0, 2));
        b = 2'($urandom_range(a + 1, 3));
        beat(1, 8'($urandom), 8'($urandom), a, b, $urandom, last);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(7));
        rst = 1'b1; grp_valid = 0; grp_wgt = 0; grp_idx = 0; grp_act = 0; grp_last = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        tag = "R8";
        check("reset res_valid", longint'(res_valid), 0);
        check("reset res_sum", longint'(res_sum), 0);
        check("reset meta_err", longint'(meta_err), 0);
        check("reset grp_ready R4", longint'(grp_ready), 0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        tag = "R4";
        check("grp_ready after reset", longint'(grp_ready), 1);

        // R1: single group, lanes 1 and 3: 3*(-2) + (-5)*7 = -41
        tag = "R1";
        beat(1, 8'd3, -8'sd5, 2'd1, 2'd3, {8'd7, 8'd100, -8'sd2, 8'd50}, 1'b1);
        check("R1 single group sum", longint'($signed(res_sum)), -41);
        // all six legal index pairs
        for (int p = 0; p < 3; p++)
            for (int q = p + 1; q < 4; q++)
                beat(1, 8'd11, -8'sd9, 2'(p), 2'(q), {8'd4, -8'sd3, 8'd2, 8'd1}, 1'b1);

        // R2: same selected lanes, different unselected lanes -> same sum
        tag = "R2";
        beat(1, 8'd10, 8'd20, 2'd0, 2'd2, {8'h00, 8'd5, 8'h00, 8'd3}, 1'b1);
        check("R2 base sum", longint'($signed(res_sum)), 130);
        beat(1, 8'd10, 8'd20, 2'd0, 2'd2, {8'h80, 8'd5, 8'h7f, 8'd3}, 1'b1);
        check("R2 unselected lanes ignored", longint'($signed(res_sum)), 130);

        // R9 and R5: bubbles inside a vector, no pulse before last
        tag = "R9";
        beat(1, 8'd1, 8'd1, 2'd0, 2'd1, {8'd0, 8'd0, 8'd2, 8'd2}, 1'b0);
        idle(); idle();
        tag = "R5";
        beat(1, 8'd1, 8'd1, 2'd2, 2'd3, {8'd3, 8'd3, 8'd0, 8'd0}, 1'b1);
        check("R5 R9 sum across bubbles", longint'($signed(res_sum)), 10);
        idle();
        check("R5 pulse is one cycle", longint'(res_valid), 0);

        // R7: back-to-back vectors restart from zero; sum held while idle
        tag = "R7";
        for (int v = 0; v < 4; v++) begin
            for (int g = 0; g < 5; g++) rand_beat(g == 4);
        end
        idle(); idle();
        check("R7 result held", longint'($signed(res_sum)), m_res);

        // R6: malformed groups mid-vector contribute zero, flag sticks
        tag = "R6";
        beat(1, 8'd2, 8'd2, 2'd0, 2'd1, {8'd0, 8'd0, 8'd1, 8'd1}, 1'b0);
        beat(1, 8'd50, 8'd50, 2'd2, 2'd2, 32'h7f7f7f7f, 1'b0);
        beat(1, 8'd50, 8'd50, 2'd3, 2'd1, 32'h7f7f7f7f, 1'b0);
        beat(1, 8'd1, 8'd1, 2'd0, 2'd3, {8'd1, 8'd0, 8'd0, 8'd1}, 1'b1);
        check("R6 bad groups add nothing", longint'($signed(res_sum)), 6);
        check("R6 flag set", longint'(meta_err), 1);
        for (int g = 0; g < 12; g++) rand_beat(g % 4 == 3);
        check("R6 flag sticky", longint'(meta_err), 1);

        // R3: 1024 extreme groups
        tag = "R3";
        for (int g = 0; g < 1024; g++)
            beat(1, 8'h80, 8'h80, 2'd0, 2'd3, 32'h80808080, g == 1023);
        check("R3 extreme 1024-group sum", longint'($signed(res_sum)), 33554432);

        tag = "R1";
        for (int g = 0; g < 200; g++) rand_beat(g % 7 == 6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule